// File: doc/BRIEF.md
# Architectural Timer Tick Generator

This block produces the count-enable pulses that advance a core's architectural timer. It also holds the free-running counter that those pulses drive. Two timebases reach it as one-cycle enable pulses in the block's clock domain: a crystal reference and an alternate source. A control register picks one of them. The chosen pulses feed a phase accumulator, and a rate register sets the ratio between output ticks and source pulses. The output tick rate equals the source rate times the rate value divided by 2^31. A rate of 0x80000000 therefore yields one tick for every source pulse.

Each tick advances the counter by one or by two; a control bit picks the step. The counter is reset to zero and wraps modulo 2^CNT_W. Software programs the block through a small word-addressed register port. Address 0 is the control word and address 1 is the rate. Reads return data combinationally. Writes take effect at the clock edge.

Top module: `local_tick_gen`

## Requirements
- R1: After reset the control word reads 0, the rate reads 0, the counter is 0 and no tick is issued.
- R2: A rate write above 0x80000000 is stored and read back as 0x80000000. Any other value is stored unchanged.
- R3: Control bit 8 selects the source: 0 uses xtalEn pulses and 1 uses altEn pulses. Pulses on the unselected source produce no tick.
- R4: Starting from a cleared phase, N selected pulses produce floor(N*rate/2^31) ticks. Examples: rate 0x20000000 gives one tick per 4 pulses, and 0x60000000 gives 3 ticks per 4 pulses.
- R5: A tick appears on timerTick in the cycle after the clock edge that sampled the pulse that caused it. With rate 0x80000000, every selected pulse gives a tick.
- R6: Control bit 9 selects the step: 0 adds 1 to the counter per tick and 1 adds 2. timerTwo is high together with a tick taken with step 2.
- R7: The counter wraps modulo 2^CNT_W.
- R8: A rate write clears the phase. Any pulse in the same cycle is dropped and gives no tick.
- R9: A rate of 0 never produces a tick.
- R10: The counter changes only in cycles where timerTick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control word, 1 = rate |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| xtalEn | input | 1 | Crystal timebase pulse |
| altEn | input | 1 | Alternate timebase pulse |
| timerTick | output | 1 | Count-enable pulse |
| timerTwo | output | 1 | Step of the current tick is 2 |
| timerCount | output | CNT_W | Timer counter value |

## Verification
Some properties are checked on every cycle. The stored rate never exceeds 0x80000000. A tick is never issued unless a pulse was accepted in the previous cycle without a rate write. The counter holds unless a tick is present, and it moves by exactly the step that timerTwo reports. A rate write leaves the phase at zero with no tick.

Other behaviour only the directed scenarios can show. These scenarios cover the tick ratios for specific rate values and source selection against the ignored source. They also cover the sequence of pulses after a phase clear and the wrap of a narrow counter instance compared with the wide one.

// File: rtl/local_tick_pkg.sv
package local_tick_pkg;
  typedef struct packed {
    logic advance;     // accepted source pulse this cycle
    logic clearPhase;  // rate write: restart the accumulator
    logic dblStep;     // step size 2 selected
  } tickStrobes_t;
endpackage

// File: rtl/local_tick_ctrl.sv
module local_tick_ctrl
  import local_tick_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int SRC_BIT  = 8,
  parameter int STEP_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [RATE_W-1:0] regWrData,
  output logic [RATE_W-1:0] regRdData,
  input  logic              xtalEn,
  input  logic              altEn,
  output logic [RATE_W-1:0] rate,
  output tickStrobes_t      strobes
);
  localparam logic [RATE_W-1:0] UNITY = RATE_W'(1) << (RATE_W - 1);

  logic srcSel;
  logic dblSel;
  logic [RATE_W-1:0] wrClamped;

  assign wrClamped = (regWrData > UNITY) ? UNITY : regWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel <= 1'b0;
      dblSel <= 1'b0;
      rate   <= '0;
    end else if (regWr) begin
      if (regAddr) begin
        rate <= wrClamped;
      end else begin
        srcSel <= regWrData[SRC_BIT];
        dblSel <= regWrData[STEP_BIT];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData = rate;
    end else begin
      regRdData[SRC_BIT]  = srcSel;
      regRdData[STEP_BIT] = dblSel;
    end
  end

  assign strobes.advance    = srcSel ? altEn : xtalEn;
  assign strobes.clearPhase = regWr && regAddr;
  assign strobes.dblStep    = dblSel;

  // R2
  rate_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rate <= UNITY);
endmodule

// File: rtl/local_tick_dp.sv
module local_tick_dp
  import local_tick_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strobes,
  input  logic [RATE_W-1:0] rate,
  output logic              tick,
  output logic              two,
  output logic [CNT_W-1:0]  count
);
  logic [RATE_W-1:0] phase;
  logic [RATE_W:0]   sum;
  logic [CNT_W-1:0]  step;

  // Adding twice the rate makes the carry rate equal to rate/2^31.
  assign sum  = {1'b0, phase} + {rate, 1'b0};
  assign step = strobes.dblStep ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      tick  <= 1'b0;
      two   <= 1'b0;
      count <= '0;
    end else begin
      tick <= 1'b0;
      if (strobes.clearPhase) begin
        phase <= '0;
      end else if (strobes.advance) begin
        phase <= sum[RATE_W-1:0];
        tick  <= sum[RATE_W];
        if (sum[RATE_W]) begin
          two   <= strobes.dblStep;
          count <= count + step;
        end
      end
    end
  end

  // R5
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> $past(strobes.advance && !strobes.clearPhase));

  // R8
  clear_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clearPhase) |-> (!tick && phase == '0));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> count == $past(count));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> count == $past(count) + (two ? CNT_W'(2) : CNT_W'(1)));
endmodule

// File: rtl/local_tick_gen.sv
module local_tick_gen
  import local_tick_pkg::*;
#(
  parameter int RATE_W   = 32,
  parameter int CNT_W    = 64,
  parameter int SRC_BIT  = 8,
  parameter int STEP_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [RATE_W-1:0] regWrData,
  output logic [RATE_W-1:0] regRdData,
  input  logic              xtalEn,
  input  logic              altEn,
  output logic              timerTick,
  output logic              timerTwo,
  output logic [CNT_W-1:0]  timerCount
);
  tickStrobes_t      strobes;
  logic [RATE_W-1:0] rate;

  local_tick_ctrl #(
    .RATE_W(RATE_W), .SRC_BIT(SRC_BIT), .STEP_BIT(STEP_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .xtalEn(xtalEn), .altEn(altEn), .rate(rate), .strobes(strobes)
  );

  local_tick_dp #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rate(rate),
    .tick(timerTick), .two(timerTwo), .count(timerCount)
  );
endmodule

// File: tb/local_tick_gen_bench.sv
module local_tick_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] rdNarrow;
  logic xtalEn = 1'b0;
  logic altEn = 1'b0;
  logic timerTick, timerTwo, tickN, twoN;
  logic [63:0] timerCount;
  logic [3:0]  countN;

  int checks = 0;
  int fails = 0;
  int tickCnt = 0;
  logic [63:0] expCount = '0;

  always #2 clk = ~clk;

  local_tick_gen u_local_tick_gen (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xtalEn(xtalEn),
    .altEn(altEn), .timerTick(timerTick), .timerTwo(timerTwo),
    .timerCount(timerCount)
  );

  local_tick_gen #(.CNT_W(4)) u_narrow (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdNarrow), .xtalEn(xtalEn),
    .altEn(altEn), .timerTick(tickN), .timerTwo(twoN), .timerCount(countN)
  );

  always @(negedge clk) if (rstN && timerTick) tickCnt++;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // n pulses on one source; returns ticks seen
  task automatic pulse(input bit useAlt, input int n, output int seen);
    int start;
    start = tickCnt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xtalEn = !useAlt; altEn = useAlt;
    end
    @(negedge clk);
    xtalEn = 1'b0; altEn = 1'b0;
    @(negedge clk);
    seen = tickCnt - start;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(timerCount == 0, "R1 count", timerCount, 0);
    check(!timerTick, "R1 tick", timerTick, 0);
    readReg(1'b0, d); check(d == 0, "R1 control", d, 0);
    readReg(1'b1, d); check(d == 0, "R1 rate", d, 0);
  endtask

  task automatic t_clamp();
    logic [31:0] d;
    writeReg(1'b1, 32'hFFFF_FFFF);
    readReg(1'b1, d); check(d == 32'h8000_0000, "R2 clamp", d, 32'h8000_0000);
    writeReg(1'b1, 32'h8000_0001);
    readReg(1'b1, d); check(d == 32'h8000_0000, "R2 clamp edge", d, 32'h8000_0000);
    writeReg(1'b1, 32'h1234_5678);
    readReg(1'b1, d); check(d == 32'h1234_5678, "R2 keep", d, 32'h1234_5678);
  endtask

  task automatic t_unity();
    int seen;
    writeReg(1'b0, 32'h0);
    writeReg(1'b1, 32'h8000_0000);
    // single pulse latency
    @(negedge clk); xtalEn = 1'b1;
    @(negedge clk); xtalEn = 1'b0;
    check(timerTick, "R5 tick after pulse", timerTick, 1);
    @(negedge clk);
    check(!timerTick, "R5 tick one cycle", timerTick, 0);
    expCount += 1;
    pulse(1'b0, 10, seen);
    check(seen == 10, "R5 unity ticks", seen, 10);
    expCount += 10;
    check(timerCount == expCount, "R6 count step1", timerCount, expCount);
  endtask

  task automatic t_ratio();
    int seen;
    writeReg(1'b1, 32'h2000_0000);
    pulse(1'b0, 16, seen);
    check(seen == 4, "R4 quarter", seen, 4);
    expCount += 4;
    writeReg(1'b1, 32'h6000_0000);
    pulse(1'b0, 8, seen);
    check(seen == 6, "R4 three quarters", seen, 6);
    expCount += 6;
    check(timerCount == expCount, "R4 count", timerCount, expCount);
  endtask

  task automatic t_source();
    int seen;
    writeReg(1'b1, 32'h8000_0000);
    pulse(1'b1, 5, seen);
    check(seen == 0, "R3 alt ignored", seen, 0);
    writeReg(1'b0, 32'h100);
    pulse(1'b0, 5, seen);
    check(seen == 0, "R3 xtal ignored", seen, 0);
    pulse(1'b1, 5, seen);
    check(seen == 5, "R3 alt used", seen, 5);
    expCount += 5;
    check(timerCount == expCount, "R10 count after ignored", timerCount, expCount);
  endtask

  task automatic t_step();
    int seen;
    writeReg(1'b0, 32'h200);
    @(negedge clk); xtalEn = 1'b1;
    @(negedge clk); xtalEn = 1'b0;
    check(timerTwo && timerTick, "R6 two flag", {timerTwo, timerTick}, 2'b11);
    expCount += 2;
    pulse(1'b0, 3, seen);
    expCount += 6;
    check(timerCount == expCount, "R6 count step2", timerCount, expCount);
    writeReg(1'b0, 32'h0);
  endtask

  task automatic t_zero();
    int seen;
    writeReg(1'b1, 32'h0);
    pulse(1'b0, 12, seen);
    check(seen == 0, "R9 zero rate", seen, 0);
    check(timerCount == expCount, "R10 hold", timerCount, expCount);
  endtask

  task automatic t_clear();
    int seen;
    writeReg(1'b1, 32'h4000_0000);
    pulse(1'b0, 1, seen);            // phase at half
    check(seen == 0, "R4 half first", seen, 0);
    @(negedge clk);                  // write with pulse in same cycle
    regWr = 1'b1; regAddr = 1'b1; regWrData = 32'h4000_0000; xtalEn = 1'b1;
    @(negedge clk);
    regWr = 1'b0; xtalEn = 1'b0;
    check(!timerTick, "R8 dropped pulse", timerTick, 0);
    pulse(1'b0, 1, seen);
    check(seen == 0, "R8 phase cleared", seen, 0);
    pulse(1'b0, 1, seen);
    check(seen == 1, "R8 tick after clear", seen, 1);
    expCount += 1;
  endtask

  task automatic t_wrap();
    check(timerCount == expCount, "R7 wide total", timerCount, expCount);
    check(expCount > 16, "R7 wrap reached", expCount, 17);
    check(countN == expCount[3:0], "R7 narrow wrap", countN, expCount[3:0]);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_clamp();
        t_unity();
        t_ratio();
        t_source();
        t_step();
        t_zero();
        t_clear();
        t_wrap();
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule